// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns bytes into an asynchronous serial frame. A byte written into a single holding register moves into a shift stage at a bit boundary. The shift stage then sends a start bit, the data bits with the least significant bit first, an optional parity bit and the stop bits. A separate 7-bit control word sets the frame shape: word length, stop count, parity mode and a break override. A 16-bit divisor sets the line rate.

The divisor produces one enable pulse every `divisor` clock cycles. Each bit lasts sixteen of these pulses. The divisor is therefore the input clock divided by sixteen times the baud rate. For example, a 1.8432 MHz clock with a divisor of 12 gives 9600 baud, and with a divisor of 384 gives 300 baud.

Software or a surrounding controller can write the next byte as soon as holding-empty rises. It can tell that the line has drained when transmitter-empty is high.

Top module: `uart_tx_framer`

## Requirements
- R1: After a synchronous active-low reset, the serial output is 1, holding-empty is 1 and transmitter-empty is 1.
- R2: A nonzero divisor N yields one oversample enable every N clock cycles, and each transmitted bit lasts 16 enables (16*N cycles).
- R3: A frame is one start bit at 0, then the data bits least significant first, then stop bits at 1. The word length comes from `line_ctrl[1:0]`: 00=5, 01=6, 10=7, 11=8 bits. The line rests at 1 when nothing is sent.
- R4: With `line_ctrl[3]`=0, no parity bit is sent.
- R5: With `line_ctrl[3]`=1, the parity bit depends on `line_ctrl[5]` (stick) and `line_ctrl[4]` (even select). Stick=0 with even select=0 gives odd parity over the data bits. Stick=0 with even select=1 gives even parity. Stick=1 with even select=0 gives a constant 1. Stick=1 with even select=1 gives a constant 0.
- R6: With `line_ctrl[2]`=0, one stop bit is sent. With `line_ctrl[2]`=1, two stop bits are sent, except for a 5-bit word, which gets one and a half stop bits (24 enables).
- R7: While `line_ctrl[6]`=1, the serial output is 0, whatever the shift stage is doing. The frame keeps advancing underneath the override.
- R8: A write sets holding-empty to 0 on the next cycle. The held byte moves into the shift stage on the enable that starts the next bit period after the shift stage is free. Holding-empty returns to 1 in that same cycle.
- R9: Transmitter-empty is 1 only when the holding register and the shift stage are both empty.
- R10: A divisor of 0 stops the enable. The line stays at 1, and a pending byte is not sent until a nonzero divisor is applied.
- R11: The frame settings are captured when a byte enters the shift stage. Changing bits 0 to 5 of `line_ctrl` during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| line_ctrl | input | 7 | Frame control: [1:0] length, [2] extra stop, [3] parity on, [4] even, [5] stick, [6] break |
| divisor | input | 16 | Clock cycles per oversample enable, 0 halts |
| ser_out | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
Two situations are hard to reach from the ports.

The first is a write that lands while a frame is still on the line. Here the stop-bit end and the reload happen on the same enable, giving back-to-back frames with no idle bit between them. The bench writes the second byte a few cycles after the first byte has been taken, so the reload always meets a busy shift stage.

The second is the one-and-a-half stop bit on 5-bit words. It only changes the timing of the next frame, so the bench sends two 5-bit frames back to back to expose the short final stop bit.

The bench also changes the control word and asserts break in the middle of a frame, and holds a pending byte behind a zero divisor. Every output is compared each clock against a model built from bit-level queues.

// File: rtl/uart_tx_pkg.sv
// Package: shared types and the parity rule for the UART transmit framer.
// Assumes: control word layout [1:0] length, [2] extra stop, [3] parity on,
// [4] even select, [5] stick, [6] break.
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP1 = 3'd4,
        ST_STOP2 = 3'd5
    } tx_state_t;

    typedef struct packed {
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } lctl_t;

    // Parity bit for an already length-masked data word.
    function automatic logic parity_bit(input logic [7:0] d, input logic even, input logic stick);
        if (stick) return ~even;
        return even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/uart_baud_tick.sv
// Module: oversample enable generator.
// Produces a one-cycle pulse every DIV clock cycles; DIV of zero holds the
// pulse low and parks the counter. Assumes divisor is quasi-static.
module uart_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count cycles and emit the registered enable at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (divisor == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor - 1'b1) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R10: a zero divisor never yields an enable.
    p_no_tick_zero_div_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |=> !tick);

endmodule

// File: rtl/uart_tx_shift.sv
// Module: frame sequencer and shift stage.
// Advances one bit per OVS enables (half of that for the short final stop
// of a 5-bit word), requests a reload from the holding register on a bit
// boundary, and latches the frame settings at reload.
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  lctl_t             lctl,
    output logic              load,
    output logic              line,
    output logic              idle
);
    localparam int SUB_W    = $clog2(OVS);
    localparam int CNT_W    = $clog2(DATA_W);
    localparam int MIN_BITS = DATA_W - 3;
    localparam logic [SUB_W-1:0] FULL_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] HALF_LAST = SUB_W'(OVS / 2 - 1);

    tx_state_t         state;
    logic [SUB_W-1:0]  sub;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    lctl_t             cfg;
    logic [SUB_W-1:0]  last_sub;
    logic              bit_end;
    logic              frame_end;
    logic [CNT_W-1:0]  last_bit;
    logic [DATA_W-1:0] masked;

    // Mask the held byte down to the selected word length.
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            masked[i] = hold_data[i] && (i < MIN_BITS + int'(lctl.wlen));
    end

    // Bit boundary, frame end and reload request.
    always_comb begin
        last_sub  = (state == ST_STOP2 && cfg.wlen == 2'd0) ? HALF_LAST : FULL_LAST;
        bit_end   = tick && (sub == last_sub);
        frame_end = bit_end && ((state == ST_STOP2) || (state == ST_STOP1 && !cfg.two_stop));
        load      = hold_full && ((state == ST_IDLE && bit_end) || frame_end);
        last_bit  = CNT_W'(MIN_BITS - 1) + CNT_W'(cfg.wlen);
    end

    // Line level for the current state.
    always_comb begin
        unique case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
        idle = (state == ST_IDLE);
    end

    // Oversample position within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       sub <= '0;
        else if (bit_end) sub <= '0;
        else if (tick)    sub <= sub + 1'b1;
    end

    // Frame sequencing, shifting and settings capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            par_q  <= 1'b0;
            cfg    <= '0;
        end else if (load) begin
            state  <= ST_START;
            shreg  <= masked;
            par_q  <= parity_bit(masked, lctl.even, lctl.stick);
            cfg    <= lctl;
            bitcnt <= '0;
        end else if (bit_end) begin
            unique case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                    shreg  <= shreg >> 1;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == last_bit) state <= cfg.par_en ? ST_PAR : ST_STOP1;
                end
                ST_PAR:   state <= ST_STOP1;
                ST_STOP1: state <= cfg.two_stop ? ST_STOP2 : ST_IDLE;
                ST_STOP2: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R2: without an enable the sequencer holds its state.
    p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));

    // R8: a reload leaves the sequencer in the start bit.
    p_load_enters_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state == ST_START));

endmodule

// File: rtl/uart_tx_framer.sv
// Module: top of the UART transmit framer.
// Holds one byte for the shift stage, applies the break override and
// reports empty status. Assumes a write while full overwrites the byte.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [6:0]        line_ctrl,
    input  logic [DIV_W-1:0]  divisor,
    output logic              ser_out,
    output logic              hold_empty,
    output logic              tx_empty
);
    lctl_t             lctl;
    logic              tick;
    logic              load;
    logic              line;
    logic              idle;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;

    assign lctl = lctl_t'(line_ctrl);

    uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .lctl      (lctl),
        .load      (load),
        .line      (line),
        .idle      (idle)
    );

    // Holding register: a write fills it, a reload empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (wr_en) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    // Output drive with the break override and status flags.
    always_comb begin
        ser_out    = lctl.brk ? 1'b0 : line;
        hold_empty = !hold_full;
        tx_empty   = hold_empty && idle;
    end

    // R8: a write fills the holding register.
    p_write_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    // R8: holding-empty rises only on an oversample enable.
    p_empty_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> $past(tick));

    // R3: a drained transmitter rests at mark unless break is forced.
    p_idle_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !line_ctrl[6]) |-> ser_out);

endmodule

// File: tb/uart_tx_framer_bench.sv
// Bench: behavioural queue model compared with the framer every clock.
module uart_tx_framer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [6:0]  line_ctrl = '0;
    logic [15:0] divisor = 16'd1;
    logic        ser_out, hold_empty, tx_empty;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string req_tag = "R3";

    // model state
    bit     q[$];
    bit     m_full = 0;
    bit [7:0] m_data = 0;
    bit     m_tick = 0;
    int     m_cnt = 0;
    int     m_phase = 0;

    always #2 clk = ~clk;

    uart_tx_framer u_uart_tx_framer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .line_ctrl(line_ctrl), .divisor(divisor),
        .ser_out(ser_out), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Build the tick-level frame from the byte and the settings in force.
    task automatic model_load();
        int nb, ones;
        bit p;
        nb = 5 + int'(line_ctrl[1:0]);
        ones = 0;
        m_full = 0;
        for (int i = 0; i < 16; i++) q.push_back(1'b0);
        for (int b = 0; b < nb; b++) begin
            ones += int'(m_data[b]);
            for (int i = 0; i < 16; i++) q.push_back(m_data[b]);
        end
        if (line_ctrl[3]) begin
            if (line_ctrl[5]) p = !line_ctrl[4];
            else p = line_ctrl[4] ? bit'(ones % 2) : bit'((ones + 1) % 2);
            for (int i = 0; i < 16; i++) q.push_back(p);
        end
        for (int i = 0; i < 16; i++) q.push_back(1'b1);
        if (line_ctrl[2])
            for (int i = 0; i < (nb == 5 ? 8 : 16); i++) q.push_back(1'b1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q.delete(); m_full = 0; m_tick = 0; m_cnt = 0; m_phase = 0;
        end else begin
            if (m_tick) begin
                if (q.size() > 1) void'(q.pop_front());
                else if (q.size() == 1) begin
                    void'(q.pop_front());
                    m_phase = 0;
                    if (m_full) model_load();
                end else if (m_phase == 15) begin
                    m_phase = 0;
                    if (m_full) model_load();
                end else m_phase++;
            end
            if (wr_en) begin m_full = 1; m_data = wr_data; end
            if (divisor == 0) begin m_cnt = 0; m_tick = 0; end
            else if (m_cnt >= int'(divisor) - 1) begin m_cnt = 0; m_tick = 1; end
            else begin m_cnt++; m_tick = 0; end
        end
    end

    // Compare every clock, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check(req_tag, ser_out, line_ctrl[6] ? 1'b0 : (q.size() != 0 ? q[0] : 1'b1), "ser_out");
            check("R8", hold_empty, !m_full, "hold_empty");
            check("R9", tx_empty, !m_full && q.size() == 0, "tx_empty");
        end
    end

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (q.size() == 0 && !m_full) break;
        end
        repeat (40) @(negedge clk);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cycles(4);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", ser_out, 1'b1, "reset ser_out");
        check("R1", hold_empty, 1'b1, "reset hold_empty");
        check("R1", tx_empty, 1'b1, "reset tx_empty");

        // R3 R8: 8N1, second byte written while first is on the line
        req_tag = "R3"; line_ctrl = 7'b000_0011; divisor = 16'd1;
        write_byte(8'hA5);
        wait_cycles(30);
        write_byte(8'h3C);
        wait_drain();

        // R4: 6 bits, parity off, two stop
        req_tag = "R4"; line_ctrl = 7'b000_0101;
        write_byte(8'h2B);
        wait_drain();

        // R5: 7 bits even parity, odd parity on 6 bits
        req_tag = "R5"; line_ctrl = 7'b001_1010;
        write_byte(8'h55); wait_drain();
        line_ctrl = 7'b000_1001;
        write_byte(8'h07); wait_drain();
        // R5: stick parity, constant 1 then constant 0, 8 bits
        line_ctrl = 7'b010_1011;
        write_byte(8'h00); wait_drain();
        line_ctrl = 7'b011_1011;
        write_byte(8'hFF); wait_drain();

        // R6: 5 bits, 1.5 stop bits, back to back
        req_tag = "R6"; line_ctrl = 7'b000_0100;
        write_byte(8'h1D);
        wait_cycles(20);
        write_byte(8'h0A);
        wait_drain();

        // R2: divisor 3 stretches every bit
        req_tag = "R2"; divisor = 16'd3; line_ctrl = 7'b001_1011;
        write_byte(8'hC3);
        wait_drain();

        // R7: break asserted in the middle of a frame
        req_tag = "R7"; divisor = 16'd1; line_ctrl = 7'b000_0011;
        write_byte(8'hFF);
        wait_cycles(50);
        line_ctrl = 7'b100_0011;
        wait_cycles(40);
        line_ctrl = 7'b000_0011;
        wait_drain();

        // R11: settings changed mid-frame apply to later frames only
        req_tag = "R11"; line_ctrl = 7'b000_0011;
        write_byte(8'h96);
        wait_cycles(60);
        line_ctrl = 7'b001_1100;
        wait_drain();

        // R10: zero divisor halts, pending byte waits
        req_tag = "R10"; line_ctrl = 7'b000_0011;
        wait_cycles(2);
        divisor = 16'd0;
        wait_cycles(3);
        write_byte(8'h81);
        wait_cycles(500);
        check("R10", ser_out, 1'b1, "halted line");
        check("R10", hold_empty, 1'b0, "pending byte held");
        divisor = 16'd2;
        wait_drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule